// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead-Time Insertion

This block drives one full H-bridge. It takes two direction bits, an active-high run bit, a PWM bit and a fault-disable bit, and it produces four registered gate enables: a high-side and a low-side switch for each of the two bridge legs, named leg A and leg B. The mode is decoded from the direction bits and the PWM level. During the PWM-low phase, and whenever both direction bits are set, the bridge goes to short brake, with both low-side switches on. This gives synchronous rectification without any off-time supplied from outside.

Each leg has its own dead-time sequencer. When a leg moves from its high switch to its low switch, or the other way, both switches stay off for `DEAD_CYC` clock cycles before the new switch turns on. This covers PWM chopping, a change between drive and brake, and a direct reversal of direction. The direction, run and PWM inputs pass through two-flop synchronizers before they are decoded. The fault-disable input is taken as synchronous to the clock and acts on the very next edge.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With run_en=1, dir_a=1 and dir_b=1, the outputs settle to short brake, {hs_a,ls_a,hs_b,ls_b}=4'b0101, for either PWM level.
- R2: With run_en=1, dir_a=0 and dir_b=0, all four enables settle to 0 (stop).
- R3: With run_en=1, dir_a=0 and dir_b=1, PWM high settles to 4'b0110 (leg A low, leg B high), and PWM low settles to short brake 4'b0101.
- R4: With run_en=1, dir_a=1 and dir_b=0, PWM high settles to 4'b1001 (leg A high, leg B low), and PWM low settles to short brake 4'b0101.
- R5: With run_en=0, all four enables settle to 0 whatever the direction and PWM inputs are.
- R6: A leg never has its high and low enables set in the same cycle.
- R7: When a leg changes directly between high and low, including a reversal from 4'b1001 to 4'b0110, both of its enables are 0 for exactly DEAD_CYC cycles before the new switch turns on.
- R8: A PWM-high pulse of W cycles, with W greater than DEAD_CYC, in the 1/0 direction mode, from brake, yields exactly W-DEAD_CYC cycles of hs_a, and every pulse in a train yields one hs_a pulse.
- R9: fault_off=1 clears all four enables at the next clock edge and holds them clear. After release, a leg turns the switch it last drove back on at once, and turns the opposite switch on only once DEAD_CYC off cycles have elapsed.
- R10: Reset clears all enables. A change on dir/run/pwm first shows at the outputs after the third rising edge: two synchronizer stages, then the output register. A leg that has not yet driven since reset turns on with no dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_a | input | 1 | Direction bit 1 (asynchronous) |
| dir_b | input | 1 | Direction bit 2 (asynchronous) |
| run_en | input | 1 | 1 = run, 0 = standby (asynchronous) |
| pwm_in | input | 1 | PWM chop input (asynchronous) |
| fault_off | input | 1 | Synchronous fault disable, forces all enables off |
| hs_a | output | 1 | Leg A high-side enable |
| ls_a | output | 1 | Leg A low-side enable |
| hs_b | output | 1 | Leg B high-side enable |
| ls_b | output | 1 | Leg B low-side enable |

## Verification
The decoder is exercised with all four direction codes, each at both PWM levels. This separates brake, stop and the two drive polarities, and shows that the PWM level matters only in the two drive codes. Standby is applied with drive and brake codes, to show that the run bit overrides the decoder. A direct reversal and a train of PWM pulses measure the off gap and the on-time cycle by cycle, which exposes a dead time that is wrong by one cycle as well as any lost pulse. The fault tests change the direction while the fault is held, to separate a restart on the same side from a restart on the opposite side.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_drv_e;

    localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
    import hbg_pkg::*;
(
    input  logic     dir_a,
    input  logic     dir_b,
    input  logic     run_en,
    input  logic     pwm_in,
    output leg_drv_e tgt_a,
    output leg_drv_e tgt_b
);
    always_comb begin
        tgt_a = LEG_OFF;
        tgt_b = LEG_OFF;
        if (run_en) begin
            unique case ({dir_a, dir_b})
                2'b11: begin
                    tgt_a = LEG_LO;
                    tgt_b = LEG_LO;
                end
                2'b01: begin
                    tgt_a = LEG_LO;
                    tgt_b = pwm_in ? LEG_HI : LEG_LO;
                end
                2'b10: begin
                    tgt_a = pwm_in ? LEG_HI : LEG_LO;
                    tgt_b = LEG_LO;
                end
                default: begin
                    tgt_a = LEG_OFF;
                    tgt_b = LEG_OFF;
                end
            endcase
        end
    end
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 30
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fault_off,
    input  leg_drv_e tgt,
    output logic     hs_en,
    output logic     ls_en
);
    localparam int unsigned CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(DEAD_CYC - 1);

    typedef struct packed {
        leg_drv_e         drive;
        leg_drv_e         last;
        logic [CNT_W-1:0] cnt;
    } leg_st_t;

    leg_st_t st_d;
    leg_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.drive == LEG_OFF && st_q.cnt != CNT_SAT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (fault_off || tgt == LEG_OFF) begin
            if (st_q.drive != LEG_OFF) begin
                st_d.drive = LEG_OFF;
                st_d.cnt   = '0;
            end
        end else if (st_q.drive == LEG_OFF) begin
            if (st_q.last == LEG_OFF || st_q.last == tgt || st_q.cnt == CNT_SAT) begin
                st_d.drive = tgt;
                st_d.last  = tgt;
            end
        end else if (st_q.drive != tgt) begin
            st_d.drive = LEG_OFF;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{drive: LEG_OFF, last: LEG_OFF, cnt: CNT_SAT};
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_en = (st_q.drive == LEG_HI);
    assign ls_en = (st_q.drive == LEG_LO);
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int unsigned DEAD_CYC    = 30,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_a,
    input  logic dir_b,
    input  logic run_en,
    input  logic pwm_in,
    input  logic fault_off,
    output logic hs_a,
    output logic ls_a,
    output logic hs_b,
    output logic ls_b
);
    localparam int unsigned CTL_W = 4;

    logic [CTL_W-1:0] ctl_sync;
    leg_drv_e         tgt [NUM_LEGS];
    logic             hs_v [NUM_LEGS];
    logic             ls_v [NUM_LEGS];

    hbg_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dir_a, dir_b, run_en, pwm_in}),
        .sync_o  (ctl_sync)
    );

    hbg_decode dec_i (
        .dir_a  (ctl_sync[3]),
        .dir_b  (ctl_sync[2]),
        .run_en (ctl_sync[1]),
        .pwm_in (ctl_sync[0]),
        .tgt_a  (tgt[0]),
        .tgt_b  (tgt[1])
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbg_leg #(.DEAD_CYC(DEAD_CYC)) leg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .fault_off (fault_off),
            .tgt       (tgt[g]),
            .hs_en     (hs_v[g]),
            .ls_en     (ls_v[g])
        );
    end

    assign hs_a = hs_v[0];
    assign ls_a = ls_v[0];
    assign hs_b = hs_v[1];
    assign ls_b = ls_v[1];
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk #(
    parameter int unsigned DEAD_CYC = 30
) (
    input logic clk,
    input logic rst_n,
    input logic fault_off,
    input logic hs_a,
    input logic ls_a,
    input logic hs_b,
    input logic ls_b
);
    localparam int unsigned CW = $clog2(DEAD_CYC + 1) + 1;
    localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

    logic [CW-1:0] off_a_q, off_b_q;
    logic          was_lo_a_q, was_hi_a_q, was_lo_b_q, was_hi_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_a_q    <= SAT;
            off_b_q    <= SAT;
            was_lo_a_q <= 1'b0;
            was_hi_a_q <= 1'b0;
            was_lo_b_q <= 1'b0;
            was_hi_b_q <= 1'b0;
        end else begin
            if (hs_a || ls_a) begin
                off_a_q    <= '0;
                was_lo_a_q <= ls_a;
                was_hi_a_q <= hs_a;
            end else if (off_a_q != SAT) begin
                off_a_q <= off_a_q + 1'b1;
            end
            if (hs_b || ls_b) begin
                off_b_q    <= '0;
                was_lo_b_q <= ls_b;
                was_hi_b_q <= hs_b;
            end else if (off_b_q != SAT) begin
                off_b_q <= off_b_q + 1'b1;
            end
        end
    end

    assert_no_overlap_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a && ls_a));
    assert_no_overlap_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_b && ls_b));
    assert_fault_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_off |=> !(hs_a || ls_a || hs_b || ls_b));
    assert_dead_hs_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_a) && was_lo_a_q) |-> (off_a_q >= SAT));
    assert_dead_ls_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_a) && was_hi_a_q) |-> (off_a_q >= SAT));
    assert_dead_hs_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_b) && was_lo_b_q) |-> (off_b_q >= SAT));
    assert_dead_ls_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_b) && was_hi_b_q) |-> (off_b_q >= SAT));
endmodule

bind hbridge_gate_ctrl hbg_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_off (fault_off),
    .hs_a      (hs_a),
    .ls_a      (ls_a),
    .hs_b      (hs_b),
    .ls_b      (ls_b)
);

// File: tb/hbridge_gate_ctrl_tb_top.sv
module hbridge_gate_ctrl_tb_top;
    localparam int DT = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_a = 1'b0, dir_b = 1'b0, run_en = 1'b0, pwm_in = 1'b0, fault_off = 1'b0;
    logic hs_a, ls_a, hs_b, ls_b;
    int   errors = 0;
    int   checks = 0;
    int   overlap_cnt = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    hbridge_gate_ctrl #(.DEAD_CYC(DT)) dut_i (
        .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .run_en(run_en),
        .pwm_in(pwm_in), .fault_off(fault_off),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
    );

    function automatic logic [3:0] outs();
        return {hs_a, ls_a, hs_b, ls_b};
    endfunction

    always @(negedge clk) begin
        if (rst_n && ((hs_a && ls_a) || (hs_b && ls_b))) overlap_cnt++;
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_in(logic d1, logic d2, logic run, logic pwm);
        @(negedge clk);
        dir_a = d1; dir_b = d2; run_en = run; pwm_in = pwm;
    endtask

    task automatic settle();
        repeat (DT + 8) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10", "outputs in reset", outs(), 4'b0000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R10", "outputs after reset", outs(), 4'b0000);
    endtask

    task automatic t_latency();
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R10", "after two edges", outs(), 4'b0000);
        @(negedge clk);
        chk("R10", "after third edge, fresh leg no dead time", outs(), 4'b0101);
    endtask

    task automatic t_brake();
        set_in(1'b1, 1'b1, 1'b1, 1'b1);
        settle();
        chk("R1", "brake pwm high", outs(), 4'b0101);
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        settle();
        chk("R1", "brake pwm low", outs(), 4'b0101);
    endtask

    task automatic t_stop();
        set_in(1'b0, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R2", "stop pwm high", outs(), 4'b0000);
        set_in(1'b0, 1'b0, 1'b1, 1'b0);
        settle();
        chk("R2", "stop pwm low", outs(), 4'b0000);
    endtask

    task automatic t_dir01();
        set_in(1'b0, 1'b1, 1'b1, 1'b1);
        settle();
        chk("R3", "dir 01 pwm high", outs(), 4'b0110);
        set_in(1'b0, 1'b1, 1'b1, 1'b0);
        settle();
        chk("R3", "dir 01 pwm low brake", outs(), 4'b0101);
    endtask

    task automatic t_dir10();
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R4", "dir 10 pwm high", outs(), 4'b1001);
        set_in(1'b1, 1'b0, 1'b1, 1'b0);
        settle();
        chk("R4", "dir 10 pwm low brake", outs(), 4'b0101);
    endtask

    task automatic t_standby();
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        settle();
        chk("R5", "standby over drive", outs(), 4'b0000);
        set_in(1'b1, 1'b1, 1'b0, 1'b0);
        settle();
        chk("R5", "standby over brake", outs(), 4'b0000);
    endtask

    task automatic t_reverse();
        int off_a = 0;
        int off_b = 0;
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        chk("R7", "pre-reversal drive", outs(), 4'b1001);
        set_in(1'b0, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < DT + 20; i++) begin
            @(negedge clk);
            if (!hs_a && !ls_a) off_a++;
            if (!hs_b && !ls_b) off_b++;
        end
        chk("R7", "leg A off cycles on reversal", off_a, DT);
        chk("R7", "leg B off cycles on reversal", off_b, DT);
        chk("R7", "post-reversal drive", outs(), 4'b0110);
    endtask

    task automatic t_pwm_train();
        int hs_cycles = 0;
        int rises = 0;
        logic prev = 1'b0;
        set_in(1'b1, 1'b0, 1'b1, 1'b0);
        settle();
        for (int p = 0; p < 3; p++) begin
            @(negedge clk);
            pwm_in = 1'b1;
            for (int i = 0; i < 250; i++) begin
                if (i == 100) pwm_in = 1'b0;
                if (hs_a) hs_cycles++;
                if (hs_a && !prev) rises++;
                prev = hs_a;
                @(negedge clk);
            end
        end
        for (int i = 0; i < DT + 8; i++) begin
            if (hs_a) hs_cycles++;
            if (hs_a && !prev) rises++;
            prev = hs_a;
            @(negedge clk);
        end
        chk("R8", "hs_a on-cycles over 3 pulses", hs_cycles, 3 * (100 - DT));
        chk("R8", "hs_a pulse count", rises, 3);
        chk("R8", "back to brake", outs(), 4'b0101);
    endtask

    task automatic t_fault();
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        @(negedge clk);
        fault_off = 1'b1;
        @(negedge clk);
        chk("R9", "one edge after fault", outs(), 4'b0000);
        set_in(1'b0, 1'b1, 1'b1, 1'b1);
        settle();
        chk("R9", "held off under fault", outs(), 4'b0000);
        @(negedge clk);
        fault_off = 1'b0;
        @(negedge clk);
        chk("R9", "release after full gap", outs(), 4'b0110);
        @(negedge clk);
        fault_off = 1'b1;
        @(negedge clk);
        set_in(1'b1, 1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        fault_off = 1'b0;
        @(negedge clk);
        chk("R9", "release before gap elapsed", outs(), 4'b0000);
        settle();
        chk("R9", "reaches opposite side later", outs(), 4'b1001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_brake();
        t_stop();
        t_dir01();
        t_dir10();
        t_standby();
        t_reverse();
        t_pwm_train();
        t_fault();
        chk("R6", "cycles with a leg shorted", overlap_cnt, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule